// File: doc/BRIEF.md
# Serial Byte-Programming Port Controller

This block is the target side of a two-wire programming port. A host drives a serial clock and a data line, and uses two more pins: an active-low output-enable strobe, and a busy flag that it reads back. Through this port the host writes single bytes into an internal byte-wide storage array and reads them back to check them. Every transfer is a sequence of 8-bit frames. The first frame is a command code. The next two frames carry the location, low byte first. For a write, one data frame follows.

A write does not happen at once. The last rising clock edge of the data frame starts a programming interval that lasts a fixed number of system clocks. During that interval the busy flag is high, and the port ignores the serial clock and the strobe. The stored byte takes its new value when busy drops.

A readback works differently. After the location frames, the host pulses the output-enable strobe low. That pulse copies the addressed byte into a holding register. After the strobe returns high, eight more clock pulses shift the held byte out on the data line. The block drives the line only during those eight bits.

The clock, strobe and data pins are asynchronous to the system clock. Each passes through a two-flop synchroniser, and the block detects edges on the synchronised copies.

Top module: `serial_prog_port`

## Requirements
- R1: A write transfer is the command byte 0x40, then the location low byte, then the location high byte, then one data byte. Each byte is sent least-significant bit first. Each bit is sampled on a rising edge of the serial clock, and the clock idles high.
- R2: The array holds 2^ADDR_W bytes (default ADDR_W = 8). Location bits at position ADDR_W and above are ignored, so locations that differ only in those bits select the same byte.
- R3: Busy rises within a few system clocks of the final rising clock edge of the data byte. It stays high for exactly WRITE_CYCLES system clocks. The array holds the new byte from the cycle in which busy falls.
- R4: While busy is high, serial clock edges and strobe edges are ignored. Bits clocked in during that time are not part of any frame.
- R5: A readback transfer is the command byte 0xC0, then the location low byte, then the location high byte. A low pulse on the strobe then captures the addressed byte. After the strobe returns high, the next eight clock pulses present that byte least-significant bit first. A new bit appears after each falling edge and is valid at the following rising edge.
- R6: The data-line drive enable is low at all times except one window. That window opens at the first falling clock edge after the strobe is released and closes after the eighth rising edge of that readback.
- R7: A command byte other than 0x40 or 0xC0 leaves the array and busy unchanged. The byte that follows it is decoded as a new command.
- R8: Reset (synchronous, active low) clears the bit count and the frame position, and drops busy and the drive enable. It sets every array byte to the erased value 0xFF, including while a write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_sclk | input | 1 | Serial clock from the host, idles high |
| prog_oe_n | input | 1 | Active-low output-enable strobe, idles high |
| prog_sda_i | input | 1 | Data line as seen at the pin |
| prog_sda_o | output | 1 | Value the block drives onto the data line |
| prog_sda_oe | output | 1 | Drive enable for the data line (1 = block drives) |
| prog_busy | output | 1 | High while a write interval is running |

## Verification
Several properties are checked on every cycle. The bit count and frame position stay frozen whenever a clock edge arrives while busy is high. Busy follows every write start and drops right after the commit. The drive enable is high only in the shift-out phase. An unknown command leaves the decoder waiting for a command. Reset clears busy. Three things need the bench's scenarios to show them: that written bytes come back bit for bit under aliased locations, that the busy interval is exactly WRITE_CYCLES long, and that a partial frame sent during busy or cut by reset does not shift later frames.

// File: rtl/spp_pkg.sv
// Shared constants and types for the serial byte-programming port.
// Assumes byte-wide frames and a 16-bit location field on the wire.
package spp_pkg;

    localparam int          FRAME_BITS  = 8;
    localparam int          LOC_BITS    = 16;
    localparam logic [7:0]  CMD_WRITE   = 8'h40;
    localparam logic [7:0]  CMD_READ    = 8'hC0;
    localparam logic [7:0]  ERASED_BYTE = 8'hFF;

    // Position of the decoder inside a transfer.
    typedef enum logic [2:0] {
        PH_CMD   = 3'd0,   // waiting for a command frame
        PH_LOC_L = 3'd1,   // location low frame
        PH_LOC_H = 3'd2,   // location high frame
        PH_DATA  = 3'd3,   // write data frame
        PH_STROBE= 3'd4,   // readback: waiting for strobe pulse
        PH_SHIFT = 3'd5    // readback: shifting held byte out
    } phase_t;

endpackage

// File: rtl/spp_sync.sv
// Two-flop synchroniser bank for asynchronous pin inputs.
// Assumes each input is a level signal; RST_VAL gives the idle level that
// each stage takes in reset, so no false edge appears after reset.
module spp_sync #(
    parameter int               WIDTH   = 3,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic meta_q;
        logic stab_q;

        // Two-stage capture of one pin into the system clock domain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= RST_VAL[g];
                stab_q <= RST_VAL[g];
            end else begin
                meta_q <= async_in[g];
                stab_q <= meta_q;
            end
        end

        assign sync_out[g] = stab_q;
    end

endmodule

// File: rtl/spp_timer.sv
// Write-interval timer. A start pulse loads CYCLES; busy is high while the
// count is non-zero, and commit pulses in the last busy cycle so the array
// update and the fall of busy share one clock edge.
// Assumes start never arrives while busy (the decoder is frozen then).
module spp_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic commit
);

    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYCLES);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Down-counter that measures the write interval.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start && cnt_q == '0) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign busy   = (cnt_q != '0);
    assign commit = (cnt_q == ONE);

    // R3: a write start raises busy on the next cycle.
    a_r3_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R3: busy is gone the cycle after the commit.
    a_r3_commit_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !busy);

    // R8: reset always leaves busy low.
    a_r8_reset_clears_busy: assert property (@(posedge clk)
        !rst_n |=> !busy);

endmodule

// File: rtl/spp_array.sv
// Byte-wide storage array with one asynchronous read port and one write
// port that fires on the commit pulse. Reset fills it with the erased value.
// Assumes ADDR_W is small enough that a reset fill of every byte is cheap.
module spp_array
    import spp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] mem_q [DEPTH];

    // Erase on reset, otherwise store the committed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem_q[i] <= ERASED_BYTE;
            end
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/spp_ctrl.sv
// Frame assembler and command decoder for the programming port.
// Works on synchronised pin levels, detects clock and strobe edges itself,
// assembles LSB-first frames, decodes write and readback transfers, and
// drives the data line during readback. Assumes the system clock is several
// times faster than the serial clock and that the serial clock idles high.
module spp_ctrl
    import spp_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_s,
    input  logic              oe_n_s,
    input  logic              sda_s,
    input  logic              busy,
    input  logic [7:0]        rd_data,
    output logic [ADDR_W-1:0] loc,
    output logic [7:0]        wr_byte,
    output logic              wr_start,
    output logic              sda_out,
    output logic              sda_oe
);

    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

    phase_t                 phase_q;
    logic [BIT_W-1:0]       bit_cnt_q;
    logic [FRAME_BITS-1:0]  shreg_q;
    logic                   sclk_prev_q;
    logic                   oe_prev_q;
    logic                   is_write_q;
    logic [LOC_BITS-1:0]    loc_q;
    logic [7:0]             data_q;
    logic [7:0]             hold_q;
    logic                   held_q;
    logic [BIT_W-1:0]       out_idx_q;
    logic                   sda_out_q;
    logic                   sda_oe_q;
    logic                   wr_start_q;

    logic                   sclk_rise;
    logic                   sclk_fall;
    logic                   oe_fall;
    logic                   oe_rise;
    logic                   rx_phase;
    logic                   rx_take;
    logic                   frame_done;
    logic [FRAME_BITS-1:0]  frame;

    // Edge history of the synchronised clock and strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b1;
            oe_prev_q   <= 1'b1;
        end else begin
            sclk_prev_q <= sclk_s;
            oe_prev_q   <= oe_n_s;
        end
    end

    // Edge strobes and frame-completion decode.
    always_comb begin
        sclk_rise  = sclk_s & ~sclk_prev_q;
        sclk_fall  = ~sclk_s & sclk_prev_q;
        oe_fall    = ~oe_n_s & oe_prev_q;
        oe_rise    = oe_n_s & ~oe_prev_q;
        rx_phase   = (phase_q == PH_CMD)   || (phase_q == PH_LOC_L) ||
                     (phase_q == PH_LOC_H) || (phase_q == PH_DATA);
        rx_take    = rx_phase && !busy && sclk_rise;
        frame_done = rx_take && (bit_cnt_q == LAST_BIT);
        frame      = {sda_s, shreg_q[FRAME_BITS-1:1]};
    end

    // LSB-first shift register and bit counter for incoming frames.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q   <= '0;
            bit_cnt_q <= '0;
        end else if (rx_take) begin
            shreg_q   <= frame;
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end
    end

    // Transfer sequencing: command, location, data or readback phases.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q    <= PH_CMD;
            is_write_q <= 1'b0;
            loc_q      <= '0;
            data_q     <= '0;
            hold_q     <= '0;
            held_q     <= 1'b0;
            out_idx_q  <= '0;
            sda_out_q  <= 1'b0;
            sda_oe_q   <= 1'b0;
            wr_start_q <= 1'b0;
        end else begin
            wr_start_q <= 1'b0;
            case (phase_q)
                PH_CMD: begin
                    if (frame_done) begin
                        if (frame == CMD_WRITE) begin
                            is_write_q <= 1'b1;
                            phase_q    <= PH_LOC_L;
                        end else if (frame == CMD_READ) begin
                            is_write_q <= 1'b0;
                            phase_q    <= PH_LOC_L;
                        end
                    end
                end
                PH_LOC_L: begin
                    if (frame_done) begin
                        loc_q[7:0] <= frame;
                        phase_q    <= PH_LOC_H;
                    end
                end
                PH_LOC_H: begin
                    if (frame_done) begin
                        loc_q[15:8] <= frame;
                        held_q      <= 1'b0;
                        phase_q     <= is_write_q ? PH_DATA : PH_STROBE;
                    end
                end
                PH_DATA: begin
                    if (frame_done) begin
                        data_q     <= frame;
                        wr_start_q <= 1'b1;
                        phase_q    <= PH_CMD;
                    end
                end
                PH_STROBE: begin
                    if (!busy) begin
                        if (oe_fall) begin
                            hold_q <= rd_data;
                            held_q <= 1'b1;
                        end else if (oe_rise && held_q) begin
                            out_idx_q <= '0;
                            phase_q   <= PH_SHIFT;
                        end
                    end
                end
                PH_SHIFT: begin
                    if (!busy) begin
                        if (sclk_fall) begin
                            sda_oe_q  <= 1'b1;
                            sda_out_q <= hold_q[out_idx_q];
                        end else if (sclk_rise && sda_oe_q) begin
                            if (out_idx_q == LAST_BIT) begin
                                sda_oe_q <= 1'b0;
                                phase_q  <= PH_CMD;
                            end else begin
                                out_idx_q <= out_idx_q + 1'b1;
                            end
                        end
                    end
                end
                default: phase_q <= PH_CMD;
            endcase
        end
    end

    assign loc      = loc_q[ADDR_W-1:0];
    assign wr_byte  = data_q;
    assign wr_start = wr_start_q;
    assign sda_out  = sda_out_q;
    assign sda_oe   = sda_oe_q;

    // R4: a clock edge seen during busy moves neither counter nor phase.
    a_r4_busy_freezes_rx: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && sclk_rise) |=> ($stable(bit_cnt_q) && $stable(phase_q)));

    // R6: the data line is only driven in the shift-out phase.
    a_r6_drive_only_in_shift: assert property (@(posedge clk) disable iff (!rst_n)
        sda_oe_q |-> (phase_q == PH_SHIFT));

    // R7: an unknown command keeps the decoder waiting for a command.
    a_r7_unknown_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_CMD && frame_done && frame != CMD_WRITE && frame != CMD_READ)
        |=> (phase_q == PH_CMD && !wr_start_q));

    // R3: a write start is only issued by a completed data frame.
    a_r3_start_from_data: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start_q |-> $past(phase_q == PH_DATA && frame_done));

endmodule

// File: rtl/serial_prog_port.sv
// Top level of the serial byte-programming port: synchronises the pins,
// runs the frame decoder, times the write interval and holds the array.
// Assumes the host keeps the data line stable around each rising clock edge
// and keeps its own driver off while prog_sda_oe is high.
module serial_prog_port #(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic prog_sclk,
    input  logic prog_oe_n,
    input  logic prog_sda_i,
    output logic prog_sda_o,
    output logic prog_sda_oe,
    output logic prog_busy
);

    localparam int SYNC_W = 3;

    logic [SYNC_W-1:0] pins_async;
    logic [SYNC_W-1:0] pins_sync;
    logic              busy;
    logic              commit;
    logic              wr_start;
    logic [ADDR_W-1:0] loc;
    logic [7:0]        wr_byte;
    logic [7:0]        rd_data;

    assign pins_async = {prog_sda_i, prog_oe_n, prog_sclk};

    spp_sync #(
        .WIDTH   (SYNC_W),
        .RST_VAL ({SYNC_W{1'b1}})
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_async),
        .sync_out (pins_sync)
    );

    spp_ctrl #(
        .ADDR_W (ADDR_W)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (pins_sync[0]),
        .oe_n_s   (pins_sync[1]),
        .sda_s    (pins_sync[2]),
        .busy     (busy),
        .rd_data  (rd_data),
        .loc      (loc),
        .wr_byte  (wr_byte),
        .wr_start (wr_start),
        .sda_out  (prog_sda_o),
        .sda_oe   (prog_sda_oe)
    );

    spp_timer #(
        .CYCLES (WRITE_CYCLES)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (wr_start),
        .busy   (busy),
        .commit (commit)
    );

    spp_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .wr_addr (loc),
        .wr_data (wr_byte),
        .rd_addr (loc),
        .rd_data (rd_data)
    );

    assign prog_busy = busy;

endmodule

// File: tb/serial_prog_port_tb.sv
// Self-checking bench: table-driven write/readback pairs, then directed
// tests for busy gating, unknown commands and reset.
module serial_prog_port_tb;

    localparam int ADDR_W = 8;
    localparam int WCYC   = 64;
    localparam int HALF   = 6;   // system clocks per serial half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk = 1'b1;
    logic oe_n = 1'b1;
    logic sda_host = 1'b1;
    logic sda_o;
    logic sda_oe;
    logic busy;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    serial_prog_port #(
        .ADDR_W       (ADDR_W),
        .WRITE_CYCLES (WCYC)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .prog_sclk   (sclk),
        .prog_oe_n   (oe_n),
        .prog_sda_i  (sda_host),
        .prog_sda_o  (sda_o),
        .prog_sda_oe (sda_oe),
        .prog_busy   (busy)
    );

    // {location, data}: write at location, read back at an alias of it.
    localparam logic [23:0] VEC [6] = '{
        {16'h0000, 8'hA5}, {16'h00FF, 8'h3C}, {16'h0012, 8'h00},
        {16'h0034, 8'hFF}, {16'h0056, 8'h81}, {16'hAB77, 8'h5A}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sclk = 1'b0; sda_host = b; tick(HALF);
        sclk = 1'b1; tick(HALF);
    endtask

    task automatic send_byte(input logic [7:0] b);
        for (int i = 0; i < 8; i++) send_bit(b[i]);
    endtask

    // Full write; measure=1 checks busy timing and waits for completion.
    task automatic do_write(input logic [15:0] loc, input logic [7:0] d, input bit measure);
        int hi_cnt;
        bit seen;
        send_byte(8'h40);
        send_byte(loc[7:0]);
        send_byte(loc[15:8]);
        for (int i = 0; i < 7; i++) send_bit(d[i]);
        sclk = 1'b0; sda_host = d[7]; tick(HALF);
        sclk = 1'b1;
        if (measure) begin
            hi_cnt = 0;
            seen = 1'b0;
            for (int c = 0; c < 4 * WCYC; c++) begin
                tick(1);
                if (c == HALF) chk("R3 busy high after data byte", busy, 1);
                if (busy) begin hi_cnt++; seen = 1'b1; end
                else if (seen) break;
            end
            chk("R3 busy length", hi_cnt, WCYC);
            tick(HALF);
        end
    endtask

    // Readback; returns the byte sampled at each rising edge, checks drive window.
    task automatic do_read(input logic [15:0] loc, output logic [7:0] got);
        send_byte(8'hC0);
        send_byte(loc[7:0]);
        send_byte(loc[15:8]);
        tick(HALF);
        oe_n = 1'b0; tick(2 * HALF);
        oe_n = 1'b1; tick(2 * HALF);
        chk("R6 not driven before first fall", sda_oe, 0);
        for (int i = 0; i < 8; i++) begin
            sclk = 1'b0; tick(HALF);
            chk("R6 driven during shift", sda_oe, 1);
            got[i] = sda_o;
            sclk = 1'b1; tick(HALF);
        end
        chk("R6 released after eighth bit", sda_oe, 0);
        tick(HALF);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(3);
        rst_n = 1'b1; tick(HALF);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] rd;
        tick(4);
        // R8: reset state
        chk("R8 busy after reset", busy, 0);
        chk("R8 drive enable after reset", sda_oe, 0);
        rst_n = 1'b1;
        tick(HALF);
        do_read(16'h0010, rd);
        chk("R8 erased byte", rd, 8'hFF);

        // R1 R2 R3 R5: table of writes read back through an aliased location
        for (int v = 0; v < 6; v++) begin
            do_write(VEC[v][23:8], VEC[v][7:0], 1'b1);
            do_read(VEC[v][23:8] ^ 16'h5500, rd);
            chk("R1 R2 R5 readback", rd, VEC[v][7:0]);
        end

        // R6: no drive while receiving a write frame
        sclk = 1'b0; sda_host = 1'b0; tick(HALF);
        chk("R6 not driven while receiving", sda_oe, 0);
        sclk = 1'b1; tick(HALF);
        do_reset();

        // R4: bits and strobe during busy are ignored
        do_write(16'h0020, 8'h11, 1'b0);
        tick(HALF);
        chk("R4 busy during stray bits", busy, 1);
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        oe_n = 1'b0; tick(2); oe_n = 1'b1;
        while (busy) tick(1);
        tick(HALF);
        do_write(16'h0030, 8'h22, 1'b1);
        do_read(16'h0030, rd);
        chk("R4 frame alignment after busy", rd, 8'h22);
        do_read(16'h0020, rd);
        chk("R4 first write intact", rd, 8'h11);

        // R7: unknown command is dropped, next byte is a command
        send_byte(8'h55);
        tick(HALF);
        chk("R7 no busy on unknown command", busy, 0);
        do_write(16'h0040, 8'h6B, 1'b1);
        do_read(16'h0040, rd);
        chk("R7 command after unknown", rd, 8'h6B);
        do_read(16'h0055, rd);
        chk("R7 array untouched", rd, 8'hFF);

        // R8: reset mid-frame clears bit count
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        do_reset();
        do_write(16'h0041, 8'hC3, 1'b1);
        do_read(16'h0041, rd);
        chk("R8 bit count cleared", rd, 8'hC3);

        // R8: reset while busy drops busy and erases
        do_write(16'h0042, 8'h99, 1'b0);
        tick(HALF);
        rst_n = 1'b0; tick(2);
        chk("R8 busy cleared by reset", busy, 0);
        rst_n = 1'b1; tick(HALF);
        do_read(16'h0041, rd);
        chk("R8 array erased by reset", rd, 8'hFF);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule